// File: doc/BRIEF.md
# Lockable Sensor Configuration Register

This block is the configuration register of a temperature-monitoring device. It sits behind a plain register bus: a write strobe that is already address-decoded, a write data word, and a read data word that always shows the current register view. The stored fields select how the event output behaves: comparator or interrupt mode, its polarity, whether only critical trips count, and whether the output is driven at all. The register also holds a shutdown request, a stored-only hysteresis code and two lock flags. The block decodes these fields onto dedicated outputs for the rest of the sensor.

The two lock flags are sticky. One write sets them, and after that only reset clears them. While either flag is set, the event-control fields are frozen. Shutdown may then be released but not requested. The hysteresis code stays writable. The lock levels are exported so that the alarm-window and critical-trip threshold registers can refuse their own writes. One bit position is write-only: writing 1 there produces a one-cycle clear request toward the event logic. Another bit position is read-only and mirrors whether the device is currently driving its event output.

Top module: `thermal_cfg_reg`

## Requirements
- R1: After the asynchronous active-low reset, every stored field is 0, the clear pulse is low, and the read word shows only the live event status at bit 4.
- R2: With both locks clear, a write loads bits 0 (event mode, 1 = interrupt), 1 (polarity, 1 = active high), 2 (critical-only) and 3 (output enable). These values read back at the same positions and appear on the decoded outputs after the write's clock edge.
- R3: While either lock flag is set before a write, that write leaves bits 0 to 3 unchanged.
- R4: Read bit 4 always equals the `evt_active` input, and writing bit 4 changes nothing that is stored.
- R5: Read bit 5 is always 0. A write with bit 5 set makes `clear_evt` high for exactly the one cycle after that write's clock edge, and a write with bit 5 clear leaves it low.
- R6: A write with bit 6 set sets the alarm lock, and a write with bit 7 set sets the critical lock. Each reads back at its own bit, and no later write clears it. Only reset clears it.
- R7: Bit 8 is shutdown. With both locks clear, it takes the written value. While a lock is set, a write can change it from 1 to 0 but never from 0 to 1.
- R8: Bits 10:9 hold a hysteresis code that any write loads, whatever the lock state, and that appears on `hyst_sel`.
- R9: Bits 15:11 always read as 0, whatever was written.
- R10: `alarm_lock` and `crit_lock` follow read bits 6 and 7. Every decoded output follows its read bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Address-decoded write strobe |
| wr_data | input | 16 | Write data word |
| evt_active | input | 1 | Live status: the device is driving its event output |
| rd_data | output | 16 | Current register view |
| evt_mode | output | 1 | 0 comparator, 1 interrupt |
| evt_pol | output | 1 | 0 active low, 1 active high |
| crit_only | output | 1 | Events only on critical trip |
| evt_out_en | output | 1 | Event output enabled |
| shutdown | output | 1 | Sensor shut down |
| hyst_sel | output | 2 | Stored hysteresis code |
| alarm_lock | output | 1 | Alarm-window thresholds locked |
| crit_lock | output | 1 | Critical-trip threshold locked |
| clear_evt | output | 1 | One-cycle clear-event request |

## Verification
The bench builds the block with its defaults: a 16-bit word and a 2-bit hysteresis code. With these defaults, all five reserved bits and both lock flags can be reached from random data. Lock bits are set only rarely, and periodic resets bring the register back to the unlocked state. The random runs therefore cover long stretches both with and without the freeze in force, including the shutdown release made while locked. Directed steps cover a lock and a field change made in the same write, and back-to-back clear requests.

// File: rtl/thermal_cfg_pkg.sv
package thermal_cfg_pkg;

    localparam int unsigned CTL_N     = 4;
    localparam int unsigned POS_MODE  = 0;
    localparam int unsigned POS_STAT  = 4;
    localparam int unsigned POS_CLR   = 5;
    localparam int unsigned POS_ALOCK = 6;
    localparam int unsigned POS_CLOCK = 7;
    localparam int unsigned POS_SHDN  = 8;
    localparam int unsigned POS_HYST  = 9;
    localparam int unsigned HYST_W    = 2;
    localparam int unsigned USED_W    = POS_HYST + HYST_W;

    typedef struct packed {
        logic [HYST_W-1:0] hyst;
        logic              shdn;
        logic              crit_lock;
        logic              alarm_lock;
        logic [CTL_N-1:0]  ctl;      // {out_en, crit_only, pol, mode}
        logic              clr_pulse;
    } cfg_state_t;

endpackage

// File: rtl/cfg_write_filter.sv
module cfg_write_filter
    import thermal_cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  cfg_state_t        cur,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_state_t        nxt
);

    logic locked;
    logic [CTL_N-1:0] ctl_nxt;

    assign locked = cur.alarm_lock | cur.crit_lock;

    // Lockable control bits: one identical slice per field
    for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
        assign ctl_nxt[i] = (wr_en && !locked) ? wr_data[POS_MODE + i] : cur.ctl[i];
    end

    always_comb begin
        nxt            = cur;
        nxt.ctl        = ctl_nxt;
        nxt.clr_pulse  = wr_en & wr_data[POS_CLR];
        if (wr_en) begin
            nxt.alarm_lock = cur.alarm_lock | wr_data[POS_ALOCK];
            nxt.crit_lock  = cur.crit_lock  | wr_data[POS_CLOCK];
            nxt.hyst       = wr_data[POS_HYST +: HYST_W];
            if (locked) begin
                nxt.shdn = cur.shdn & wr_data[POS_SHDN];
            end else begin
                nxt.shdn = wr_data[POS_SHDN];
            end
        end
    end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import thermal_cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  cfg_state_t        st,
    input  logic              evt_active,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        rd_data                         = '0;
        rd_data[POS_MODE +: CTL_N]      = st.ctl;
        rd_data[POS_STAT]               = evt_active;
        rd_data[POS_CLR]                = 1'b0;
        rd_data[POS_ALOCK]              = st.alarm_lock;
        rd_data[POS_CLOCK]              = st.crit_lock;
        rd_data[POS_SHDN]               = st.shdn;
        rd_data[POS_HYST +: HYST_W]     = st.hyst;
    end

endmodule

// File: rtl/thermal_cfg_reg.sv
module thermal_cfg_reg
    import thermal_cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              evt_active,
    output logic [DATA_W-1:0] rd_data,
    output logic              evt_mode,
    output logic              evt_pol,
    output logic              crit_only,
    output logic              evt_out_en,
    output logic              shutdown,
    output logic [HYST_W-1:0] hyst_sel,
    output logic              alarm_lock,
    output logic              crit_lock,
    output logic              clear_evt
);

    cfg_state_t st_d, st_q, flt_nxt;

    cfg_write_filter #(.DATA_W(DATA_W)) u_filter (
        .cur     (st_q),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .nxt     (flt_nxt)
    );

    cfg_read_mux #(.DATA_W(DATA_W)) u_rdmux (
        .st         (st_q),
        .evt_active (evt_active),
        .rd_data    (rd_data)
    );

    always_comb begin
        st_d = flt_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_mode   = st_q.ctl[0];
    assign evt_pol    = st_q.ctl[1];
    assign crit_only  = st_q.ctl[2];
    assign evt_out_en = st_q.ctl[3];
    assign shutdown   = st_q.shdn;
    assign hyst_sel   = st_q.hyst;
    assign alarm_lock = st_q.alarm_lock;
    assign crit_lock  = st_q.crit_lock;
    assign clear_evt  = st_q.clr_pulse;

endmodule

// File: rtl/thermal_cfg_reg_chk.sv
module thermal_cfg_reg_chk
    import thermal_cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              evt_mode,
    input logic              evt_pol,
    input logic              crit_only,
    input logic              evt_out_en,
    input logic              shutdown,
    input logic              alarm_lock,
    input logic              crit_lock,
    input logic              clear_evt
);

    AST_ALOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) alarm_lock |=> alarm_lock); // R6
    AST_CLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) crit_lock |=> crit_lock); // R6
    AST_CTL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_lock || crit_lock) |=> $stable({evt_out_en, crit_only, evt_pol, evt_mode})); // R3
    AST_SHDN_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((alarm_lock || crit_lock) && !shutdown) |=> !shutdown); // R7
    AST_CLR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[POS_CLR]) |=> clear_evt); // R5
    AST_CLR_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[POS_CLR]) |=> !clear_evt); // R5
    AST_CLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !rd_data[POS_CLR]); // R5
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:USED_W] == '0); // R9

endmodule

bind thermal_cfg_reg thermal_cfg_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .evt_mode   (evt_mode),
    .evt_pol    (evt_pol),
    .crit_only  (crit_only),
    .evt_out_en (evt_out_en),
    .shutdown   (shutdown),
    .alarm_lock (alarm_lock),
    .crit_lock  (crit_lock),
    .clear_evt  (clear_evt)
);

// File: tb/thermal_cfg_reg_tb_top.sv
module thermal_cfg_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        evt_active = 1'b0;
    logic [15:0] rd_data;
    logic        evt_mode, evt_pol, crit_only, evt_out_en, shutdown;
    logic [1:0]  hyst_sel;
    logic        alarm_lock, crit_lock, clear_evt;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [3:0] m_ctl;
    logic       m_al, m_cl, m_sd, m_clr;
    logic [1:0] m_hy;

    always #4 clk = ~clk;

    thermal_cfg_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .evt_active(evt_active), .rd_data(rd_data), .evt_mode(evt_mode),
        .evt_pol(evt_pol), .crit_only(crit_only), .evt_out_en(evt_out_en),
        .shutdown(shutdown), .hyst_sel(hyst_sel), .alarm_lock(alarm_lock),
        .crit_lock(crit_lock), .clear_evt(clear_evt)
    );

    function automatic logic [15:0] exp_word(input logic st);
        return {5'b0, m_hy, m_sd, m_cl, m_al, 1'b0, st, m_ctl};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctl = '0; m_al = 0; m_cl = 0; m_sd = 0; m_clr = 0; m_hy = '0;
    endtask

    task automatic model_write(input logic en, input logic [15:0] d);
        logic lk;
        lk    = m_al | m_cl;
        m_clr = en & d[5];
        if (en) begin
            if (!lk) m_ctl = d[3:0];
            m_sd = lk ? (m_sd & d[8]) : d[8];
            m_al = m_al | d[6];
            m_cl = m_cl | d[7];
            m_hy = d[10:9];
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, "/R2 R3 R4 R6 R7 R8 R9 word"}, rd_data, exp_word(evt_active));
        check({tag, "/R10 decoded"}, {evt_out_en, crit_only, evt_pol, evt_mode, shutdown,
              hyst_sel, alarm_lock, crit_lock},
              {m_ctl, m_sd, m_hy, m_al, m_cl});
        check({tag, "/R10 locks vs read"}, {alarm_lock, crit_lock}, {rd_data[6], rd_data[7]});
        check({tag, "/R5 clear pulse"}, clear_evt, m_clr);
    endtask

    // one bus cycle: drive at negedge, check at following negedge
    task automatic bus(input logic en, input logic [15:0] d, input logic st, input string tag);
        wr_en = en; wr_data = d; evt_active = st;
        @(negedge clk);
        model_write(en, d);
        wr_en = 1'b0;
        check_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        model_reset();
        do_reset();
        // R1 reset state
        evt_active = 1'b0;
        #1;
        check("R1 reset word", rd_data, 16'h0000);
        check("R1 clear low", clear_evt, 1'b0);
        evt_active = 1'b1;
        #1;
        check("R1 R4 status mirror", rd_data, 16'h0010);

        // R2 unlocked control write, R9 reserved, R4 status write ignored
        bus(1, 16'hF81B, 0, "R2 ctl write");
        bus(1, 16'h0014, 1, "R4 status bit write");
        bus(1, 16'h0620, 0, "R5 R8 clear + hyst");
        bus(1, 16'h0020, 0, "R5 back-to-back clear");
        bus(0, 16'hFFFF, 0, "R5 no write no pulse");
        bus(1, 16'h0100, 0, "R7 set shdn unlocked");
        bus(1, 16'h0000, 0, "R7 clear shdn unlocked");
        // lock and field change in same write: fields still load
        bus(1, 16'h004F, 0, "R6 alarm lock + ctl");
        bus(1, 16'h0000, 0, "R3 R6 lock held, ctl frozen");
        bus(1, 16'h0100, 0, "R7 shdn set blocked");
        bus(1, 16'h0480, 0, "R8 hyst under lock + R6 crit");
        do_reset();
        bus(1, 16'h0181, 0, "R7 shdn+crit lock");
        bus(1, 16'h0002, 1, "R3 R7 shdn clear under lock");
        bus(1, 16'h0100, 1, "R7 shdn stays clear");

        // random phase
        for (int n = 0; n < 600; n++) begin
            logic [15:0] d;
            logic        e;
            if (n % 60 == 0) do_reset();
            d = 16'($urandom);
            if ($urandom % 12 != 0) d[7:6] = 2'b00;
            e = ($urandom % 4) != 0;
            bus(e, d, 1'($urandom), "RND");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule